// File: doc/BRIEF.md
# Serial UART with Channel Test Modes

This block is a serial UART with one transmitter, one receiver and a routing stage between the cores and the two serial pins. Software, or a DMA engine driven by the request outputs, writes words into a one-word transmit holding register and reads received words from a one-word receive holding register. The transmitter has a shift register behind its holding register, so the next word can be queued while the current frame is still on the line.

A 2-bit mode input controls the routing stage. In normal mode the cores use the pins. The three test modes rewire the pins and the cores. Automatic echo sends every received bit back out, and the transmitter keeps running but stays hidden. Local loopback feeds the transmitter into the receiver internally while the transmit pin idles high. Remote loopback wires the receive pin straight to the transmit pin and stops both cores.

Top module: `uart_tm_top`

## Requirements
- R1: The mode encoding is 00 normal, 01 automatic echo, 10 local loopback and 11 remote loopback. In normal mode the transmit pin carries the transmitter output and the receiver listens to the synchronized receive pin.
- R2: A frame is one low start bit, 8 data bits sent LSB first, and one high stop bit. Each bit lasts DIV clock cycles.
- R3: A write clears tx_ready on the next edge. tx_ready sets again when the word moves into the shift register. tx_empty is 1 only when both the holding register and the shift register are empty, and tx_empty implies tx_ready.
- R4: If the holding register is reloaded before the current stop bit ends, the next start bit follows that stop bit with no idle gap.
- R5: The receiver samples each bit at mid-bit, timed from a falling start edge. It drops a start bit that is no longer low at the half-bit point and stores no word for it.
- R6: A stored word whose stop bit was sampled low raises frame_err. A good stop bit leaves frame_err low.
- R7: A stored word sets rx_ready. If rx_ready is already set when a new word is stored, overrun sets and rd_data holds the newer word. A read pulse clears rx_ready, overrun and frame_err.
- R8: In automatic echo mode, the transmit pin repeats the synchronized receive pin and the receiver still stores the word. The transmitter keeps running, but none of its bits reach the pin.
- R9: In local loopback mode, the transmitter output drives the receiver, the receive pin is ignored, and the transmit pin stays high.
- R10: In remote loopback mode, the transmit pin repeats the synchronized receive pin. The receiver stores nothing, and the transmitter starts no frame; a queued word waits in the holding register.
- R11: After the mode changes, the transmit pin follows the new routing from the next clock edge on.
- R12: dma_tx_req equals tx_ready, dma_rx_req equals rx_ready, and irq is high whenever rx_ready, overrun or frame_err is set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode | input | 2 | Channel mode (00 normal, 01 echo, 10 local, 11 remote) |
| wr_en | input | 1 | Load the transmit holding register |
| wr_data | input | 8 | Word to transmit |
| rd_en | input | 1 | Read strobe for the receive holding register |
| rd_data | output | 8 | Received word |
| rx_pin | input | 1 | Serial receive pin |
| tx_pin | output | 1 | Serial transmit pin (registered) |
| tx_ready | output | 1 | Transmit holding register is free |
| tx_empty | output | 1 | Holding register and shift register are both empty |
| rx_ready | output | 1 | Unread received word present |
| overrun | output | 1 | A word was stored while rx_ready was set |
| frame_err | output | 1 | Stop bit of the stored word was low |
| irq | output | 1 | Receive-side interrupt |
| dma_tx_req | output | 1 | DMA write request |
| dma_rx_req | output | 1 | DMA read request |

## Verification
The bench drives the transmit path with a single word, and with two words queued back to back, decoding the pin at mid-bit. This separates a correct bit order from a reversed one, and a gapless reload from one that idles between frames. The receive path gets a clean frame, a frame with a low stop bit, two unread frames and a two-cycle start glitch. These patterns separate storing, framing errors, overrun and start-bit rejection. The same byte patterns are then run through echo, local loopback and remote loopback with the receive pin held at a level the active mode must ignore. A mode switch made while the holding register is full shows both the immediate pin rerouting and the held word going out afterwards.

// File: rtl/uart_tm_pkg.sv
package uart_tm_pkg;
  typedef enum logic [1:0] {
    CH_NORMAL = 2'b00,
    CH_ECHO   = 2'b01,
    CH_LOCAL  = 2'b10,
    CH_REMOTE = 2'b11
  } chmode_e;

  typedef enum logic [1:0] {
    RX_IDLE,
    RX_START,
    RX_DATA,
    RX_STOP
  } rx_state_e;
endpackage

// File: rtl/uart_tm_route.sv
module uart_tm_route
  import uart_tm_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] mode,
  input  logic       rx_pin,
  input  logic       tx_ser,
  output logic       rx_s,
  output logic       rx_in,
  output logic       tx_en,
  output logic       rx_en,
  output logic       tx_pin
);
  chmode_e                cm;
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   pin_d;

  assign cm = chmode_e'(mode);

  always_ff @(posedge clk) begin
    if (rst) sync_q <= '1;
    else     sync_q <= {sync_q[SYNC_STAGES-2:0], rx_pin};
  end
  assign rx_s = sync_q[SYNC_STAGES-1];

  always_comb begin
    tx_en = 1'b1;
    rx_en = 1'b1;
    rx_in = rx_s;
    pin_d = tx_ser;
    unique case (cm)
      CH_NORMAL: pin_d = tx_ser;
      CH_ECHO:   pin_d = rx_s;
      CH_LOCAL: begin
        pin_d = 1'b1;
        rx_in = tx_ser;
      end
      CH_REMOTE: begin
        pin_d = rx_s;
        rx_in = 1'b1;
        tx_en = 1'b0;
        rx_en = 1'b0;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) tx_pin <= 1'b1;
    else     tx_pin <= pin_d;
  end
endmodule

// File: rtl/uart_tm_tx.sv
module uart_tm_tx #(
  parameter int DATA_W = 8,
  parameter int DIV    = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic              tx_ser,
  output logic              tx_ready,
  output logic              tx_empty
);
  localparam int FRAME = DATA_W + 2;
  localparam int CW    = (DIV > 1) ? $clog2(DIV) : 1;
  localparam int BW    = $clog2(FRAME);

  logic [DATA_W-1:0] thr;
  logic              thr_full;
  logic              busy;
  logic [FRAME-1:0]  sh;
  logic [CW-1:0]     cnt;
  logic [BW-1:0]     bitn;

  always_ff @(posedge clk) begin
    if (rst) begin
      thr      <= '0;
      thr_full <= 1'b0;
      busy     <= 1'b0;
      sh       <= '1;
      cnt      <= '0;
      bitn     <= '0;
    end else begin
      if (!en) begin
        busy <= 1'b0;
        sh   <= '1;
        cnt  <= '0;
        bitn <= '0;
      end else if (!busy) begin
        if (thr_full) begin
          sh       <= {1'b1, thr, 1'b0};
          busy     <= 1'b1;
          cnt      <= '0;
          bitn     <= '0;
          thr_full <= 1'b0;
        end
      end else if (cnt == CW'(DIV - 1)) begin
        cnt <= '0;
        if (bitn == BW'(FRAME - 1)) begin
          bitn <= '0;
          if (thr_full) begin
            sh       <= {1'b1, thr, 1'b0};
            thr_full <= 1'b0;
          end else begin
            busy <= 1'b0;
            sh   <= '1;
          end
        end else begin
          sh   <= {1'b1, sh[FRAME-1:1]};
          bitn <= bitn + 1'b1;
        end
      end else begin
        cnt <= cnt + 1'b1;
      end
      if (wr_en) begin
        thr      <= wr_data;
        thr_full <= 1'b1;
      end
    end
  end

  assign tx_ser   = sh[0];
  assign tx_ready = !thr_full;
  assign tx_empty = !thr_full && !busy;
endmodule

// File: rtl/uart_tm_rx.sv
module uart_tm_rx
  import uart_tm_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DIV    = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              rxi,
  input  logic              rd_en,
  output logic [DATA_W-1:0] rhr,
  output logic              rx_ready,
  output logic              overrun,
  output logic              frame_err
);
  localparam int CW   = (DIV > 1) ? $clog2(DIV) : 1;
  localparam int HALF = (DIV / 2 > 0) ? DIV / 2 : 1;
  localparam int BW   = (DATA_W > 1) ? $clog2(DATA_W) : 1;

  rx_state_e         st;
  logic [CW-1:0]     cnt;
  logic [BW-1:0]     bitn;
  logic [DATA_W-1:0] shreg;
  logic              prev;
  logic              done;

  always_ff @(posedge clk) begin
    if (rst) begin
      st    <= RX_IDLE;
      cnt   <= '0;
      bitn  <= '0;
      shreg <= '0;
      prev  <= 1'b1;
    end else begin
      prev <= rxi;
      if (!en) begin
        st <= RX_IDLE;
      end else begin
        unique case (st)
          RX_IDLE: if (prev && !rxi) begin
            st  <= RX_START;
            cnt <= '0;
          end
          RX_START: if (cnt == CW'(HALF - 1)) begin
            cnt  <= '0;
            bitn <= '0;
            st   <= rxi ? RX_IDLE : RX_DATA;
          end else cnt <= cnt + 1'b1;
          RX_DATA: if (cnt == CW'(DIV - 1)) begin
            cnt   <= '0;
            shreg <= {rxi, shreg[DATA_W-1:1]};
            if (bitn == BW'(DATA_W - 1)) st <= RX_STOP;
            else bitn <= bitn + 1'b1;
          end else cnt <= cnt + 1'b1;
          RX_STOP: if (cnt == CW'(DIV - 1)) begin
            cnt <= '0;
            st  <= RX_IDLE;
          end else cnt <= cnt + 1'b1;
        endcase
      end
    end
  end

  assign done = en && (st == RX_STOP) && (cnt == CW'(DIV - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      rhr       <= '0;
      rx_ready  <= 1'b0;
      overrun   <= 1'b0;
      frame_err <= 1'b0;
    end else if (done) begin
      rhr       <= shreg;
      rx_ready  <= 1'b1;
      frame_err <= !rxi;
      if (rx_ready && !rd_en) overrun <= 1'b1;
      else if (rd_en)         overrun <= 1'b0;
    end else if (rd_en) begin
      rx_ready  <= 1'b0;
      overrun   <= 1'b0;
      frame_err <= 1'b0;
    end
  end
endmodule

// File: rtl/uart_tm_top.sv
module uart_tm_top #(
  parameter int DATA_W      = 8,
  parameter int DIV         = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        mode,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  output logic [DATA_W-1:0] rd_data,
  input  logic              rx_pin,
  output logic              tx_pin,
  output logic              tx_ready,
  output logic              tx_empty,
  output logic              rx_ready,
  output logic              overrun,
  output logic              frame_err,
  output logic              irq,
  output logic              dma_tx_req,
  output logic              dma_rx_req
);
  logic tx_ser, rx_s, rx_in, tx_en, rx_en;

  uart_tm_route #(.SYNC_STAGES(SYNC_STAGES)) u_route (
    .clk(clk), .rst(rst), .mode(mode), .rx_pin(rx_pin), .tx_ser(tx_ser),
    .rx_s(rx_s), .rx_in(rx_in), .tx_en(tx_en), .rx_en(rx_en), .tx_pin(tx_pin)
  );

  uart_tm_tx #(.DATA_W(DATA_W), .DIV(DIV)) u_tx (
    .clk(clk), .rst(rst), .en(tx_en), .wr_en(wr_en), .wr_data(wr_data),
    .tx_ser(tx_ser), .tx_ready(tx_ready), .tx_empty(tx_empty)
  );

  uart_tm_rx #(.DATA_W(DATA_W), .DIV(DIV)) u_rx (
    .clk(clk), .rst(rst), .en(rx_en), .rxi(rx_in), .rd_en(rd_en),
    .rhr(rd_data), .rx_ready(rx_ready), .overrun(overrun), .frame_err(frame_err)
  );

  assign irq        = rx_ready || overrun || frame_err;
  assign dma_tx_req = tx_ready;
  assign dma_rx_req = rx_ready;
endmodule

// File: rtl/uart_tm_chk.sv
module uart_tm_chk (
  input logic       clk,
  input logic       rst,
  input logic [1:0] mode,
  input logic       wr_en,
  input logic       tx_ser,
  input logic       rx_s,
  input logic       tx_pin,
  input logic       tx_ready,
  input logic       tx_empty,
  input logic       rx_ready,
  input logic       overrun
);
  logic past_ok;
  always_ff @(posedge clk) begin
    if (rst) past_ok <= 1'b0;
    else     past_ok <= 1'b1;
  end

  // R1
  normal_route_chk: assert property (@(posedge clk) disable iff (rst)
    past_ok && $past(mode) == 2'b00 |-> tx_pin == $past(tx_ser));
  // R8
  echo_route_chk: assert property (@(posedge clk) disable iff (rst)
    past_ok && $past(mode) == 2'b01 |-> tx_pin == $past(rx_s));
  // R9
  local_idle_chk: assert property (@(posedge clk) disable iff (rst)
    past_ok && $past(mode) == 2'b10 |-> tx_pin);
  // R10
  remote_route_chk: assert property (@(posedge clk) disable iff (rst)
    past_ok && $past(mode) == 2'b11 |-> tx_pin == $past(rx_s));
  // R10
  remote_no_rx_chk: assert property (@(posedge clk) disable iff (rst)
    past_ok && $past(mode) == 2'b11 |-> !$rose(rx_ready));
  // R3
  write_busy_chk: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> !tx_ready);
  // R3
  empty_ready_chk: assert property (@(posedge clk) disable iff (rst)
    tx_empty |-> tx_ready);
  // R7
  overrun_ready_chk: assert property (@(posedge clk) disable iff (rst)
    overrun |-> rx_ready);
endmodule

bind uart_tm_top uart_tm_chk u_chk (
  .clk(clk), .rst(rst), .mode(mode), .wr_en(wr_en), .tx_ser(tx_ser),
  .rx_s(rx_s), .tx_pin(tx_pin), .tx_ready(tx_ready), .tx_empty(tx_empty),
  .rx_ready(rx_ready), .overrun(overrun)
);

// File: tb/uart_tm_top_test.sv
`timescale 1ns/1ps
module uart_tm_top_test;
  localparam int DIV = 8;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] mode = 2'b00;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic       rd_en = 1'b0;
  logic [7:0] rd_data;
  logic       rx_pin = 1'b1;
  logic       tx_pin, tx_ready, tx_empty, rx_ready, overrun, frame_err;
  logic       irq, dma_tx_req, dma_rx_req;

  int n_chk = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  uart_tm_top #(.DATA_W(8), .DIV(DIV), .SYNC_STAGES(2)) uut (
    .clk(clk), .rst(rst), .mode(mode), .wr_en(wr_en), .wr_data(wr_data),
    .rd_en(rd_en), .rd_data(rd_data), .rx_pin(rx_pin), .tx_pin(tx_pin),
    .tx_ready(tx_ready), .tx_empty(tx_empty), .rx_ready(rx_ready),
    .overrun(overrun), .frame_err(frame_err), .irq(irq),
    .dma_tx_req(dma_tx_req), .dma_rx_req(dma_rx_req)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic write_word(input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic read_word();
    @(negedge clk); rd_en = 1'b1;
    @(negedge clk); rd_en = 1'b0;
  endtask

  task automatic set_mode(input logic [1:0] m);
    @(negedge clk); mode = m;
    repeat (4) @(negedge clk);
  endtask

  task automatic drive_frame(input logic [7:0] d, input logic stopb);
    @(negedge clk); rx_pin = 1'b0;
    repeat (DIV) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      rx_pin = d[i];
      repeat (DIV) @(negedge clk);
    end
    rx_pin = stopb;
    repeat (DIV) @(negedge clk);
    rx_pin = 1'b1;
  endtask

  task automatic decode(output logic [7:0] b, output logic stopb, output int waited);
    waited = 0;
    while (tx_pin !== 1'b0 && waited < 40 * DIV) begin
      @(negedge clk); waited++;
    end
    repeat (DIV / 2) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      repeat (DIV) @(negedge clk);
      b[i] = tx_pin;
    end
    repeat (DIV) @(negedge clk);
    stopb = tx_pin;
  endtask

  task automatic t_reset();
    chk(tx_pin == 1'b1 && tx_ready && tx_empty, "R3 reset tx", {tx_pin, tx_ready, tx_empty}, 3'b111);
    chk(!rx_ready && !overrun && !frame_err && !irq, "R12 reset rx", {rx_ready, overrun, frame_err, irq}, 0);
  endtask

  task automatic t_tx_single();
    logic [7:0] b; logic sb; int w;
    @(negedge clk); wr_en = 1'b1; wr_data = 8'hC3;
    @(negedge clk); wr_en = 1'b0;
    chk(!tx_ready && !tx_empty && !dma_tx_req, "R3 write clears ready", {tx_ready, dma_tx_req}, 0);
    @(negedge clk);
    chk(tx_ready && !tx_empty, "R3 word moved to shifter", {tx_ready, tx_empty}, 2'b10);
    decode(b, sb, w);
    chk(b == 8'hC3 && sb == 1'b1, "R2 R1 normal frame", {sb, b}, 9'h1C3);
    repeat (DIV) @(negedge clk);
    chk(tx_empty, "R3 empty after frame", tx_empty, 1);
  endtask

  task automatic t_tx_b2b();
    logic [7:0] b1, b2; logic s1, s2; int w1, w2;
    write_word(8'h12);
    @(negedge clk);
    write_word(8'h8E);
    chk(!tx_ready && !tx_empty, "R3 second word queued", {tx_ready, tx_empty}, 0);
    decode(b1, s1, w1);
    decode(b2, s2, w2);
    chk(b1 == 8'h12 && s1, "R4 first frame", b1, 8'h12);
    chk(b2 == 8'h8E && s2, "R4 second frame", b2, 8'h8E);
    chk(w2 >= DIV / 2 - 1 && w2 <= DIV / 2 + 1, "R4 no gap", w2, DIV / 2);
    repeat (DIV) @(negedge clk);
  endtask

  task automatic t_rx_good();
    drive_frame(8'hA6, 1'b1);
    repeat (2) @(negedge clk);
    chk(rx_ready && rd_data == 8'hA6 && !frame_err, "R5 rx word", rd_data, 8'hA6);
    chk(irq && dma_rx_req, "R12 rx requests", {irq, dma_rx_req}, 2'b11);
    read_word();
    chk(!rx_ready && !irq, "R7 read clears", {rx_ready, irq}, 0);
  endtask

  task automatic t_rx_ferr();
    drive_frame(8'h55, 1'b0);
    repeat (2) @(negedge clk);
    chk(rx_ready && frame_err && rd_data == 8'h55, "R6 framing error", frame_err, 1);
    read_word();
    chk(!frame_err, "R7 read clears frame_err", frame_err, 0);
    repeat (DIV) @(negedge clk);
  endtask

  task automatic t_rx_overrun();
    drive_frame(8'h01, 1'b1);
    repeat (2) @(negedge clk);
    chk(!overrun, "R7 no overrun after one", overrun, 0);
    drive_frame(8'hFE, 1'b1);
    repeat (2) @(negedge clk);
    chk(overrun && rx_ready && rd_data == 8'hFE, "R7 overrun newer word", {overrun, rd_data}, 9'h1FE);
    read_word();
    chk(!overrun && !rx_ready, "R7 read clears overrun", {overrun, rx_ready}, 0);
  endtask

  task automatic t_rx_glitch();
    @(negedge clk); rx_pin = 1'b0;
    repeat (2) @(negedge clk); rx_pin = 1'b1;
    repeat (12 * DIV) @(negedge clk);
    chk(!rx_ready, "R5 glitch rejected", rx_ready, 0);
    drive_frame(8'h3A, 1'b1);
    repeat (2) @(negedge clk);
    chk(rx_ready && rd_data == 8'h3A, "R5 rx after glitch", rd_data, 8'h3A);
    read_word();
  endtask

  task automatic t_echo();
    logic [7:0] b; logic sb; int w; bit stayed_high;
    set_mode(2'b01);
    fork
      drive_frame(8'h4B, 1'b1);
      decode(b, sb, w);
    join
    repeat (4) @(negedge clk);
    chk(b == 8'h4B && sb, "R8 echoed bits", b, 8'h4B);
    chk(rx_ready && rd_data == 8'h4B, "R8 receiver in echo", rd_data, 8'h4B);
    read_word();
    write_word(8'h00);
    stayed_high = 1'b1;
    for (int i = 0; i < 12 * DIV; i++) begin
      @(negedge clk);
      if (tx_pin !== 1'b1) stayed_high = 1'b0;
    end
    chk(stayed_high, "R8 transmitter hidden", stayed_high, 1);
    chk(tx_empty, "R8 transmitter ran", tx_empty, 1);
  endtask

  task automatic t_local();
    bit stayed_high; int n;
    set_mode(2'b10);
    rx_pin = 1'b0;
    write_word(8'h3C);
    stayed_high = 1'b1;
    n = 0;
    while (!rx_ready && n < 20 * DIV) begin
      @(negedge clk); n++;
      if (tx_pin !== 1'b1) stayed_high = 1'b0;
    end
    chk(rx_ready && rd_data == 8'h3C && !frame_err, "R9 loopback word", rd_data, 8'h3C);
    chk(stayed_high, "R9 tx pin idle", stayed_high, 1);
    read_word();
    rx_pin = 1'b1;
    repeat (2 * DIV) @(negedge clk);
  endtask

  task automatic t_remote();
    logic [7:0] b; logic sb; int w;
    set_mode(2'b11);
    fork
      drive_frame(8'h96, 1'b1);
      decode(b, sb, w);
    join
    repeat (4) @(negedge clk);
    chk(b == 8'h96 && sb, "R10 remote bits", b, 8'h96);
    chk(!rx_ready, "R10 receiver off", rx_ready, 0);
    write_word(8'h5A);
    repeat (3 * DIV) @(negedge clk);
    chk(!tx_empty && !tx_ready, "R10 transmitter held", {tx_empty, tx_ready}, 0);
    rx_pin = 1'b0;
    repeat (4) @(negedge clk);
    chk(tx_pin == 1'b0, "R10 pin follows rx", tx_pin, 0);
    mode = 2'b00;
    @(negedge clk);
    chk(tx_pin == 1'b1, "R11 reroute next edge", tx_pin, 1);
    rx_pin = 1'b1;
    decode(b, sb, w);
    chk(b == 8'h5A && sb, "R11 held word sent", b, 8'h5A);
    repeat (DIV) @(negedge clk);
    chk(tx_empty && !rx_ready, "R1 normal idle", {tx_empty, rx_ready}, 2'b10);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_tx_single();
    t_tx_b2b();
    t_rx_good();
    t_rx_ferr();
    t_rx_overrun();
    t_rx_glitch();
    t_echo();
    t_local();
    t_remote();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule